// File: doc/BRIEF.md
# Serial Result Return and Status Capture

This block hands the results of a device under test back to a slow host through single-bit status lines. Two 16-bit result buses are snapshotted together into one 32-bit shift register. The host then walks the snapshot out one bit at a time on a serial line. The host does not drive a clock for this. It writes control bits, and the block acts on the rising edge of each one. One control bit takes the snapshot and another advances the register by one position.

A second path watches a set of active-low status inputs, which normally sit high. A configuration input picks one of them. A gated set/reset capture latch remembers whether that input went low while capture was armed. The latch output is steered onto one of two host status lines, and the line that is not chosen stays low. The serial line reaches the host only when serial reads are enabled.

All control bits and status inputs are brought into the system clock domain through a synchroniser before any edge is detected or anything is latched. The serialiser is a two-state machine: SH_EMPTY (nothing left to present) and SH_FULL (a snapshot is being shifted out). Its transitions are:
- SH_EMPTY to SH_FULL on a load edge.
- SH_FULL to SH_FULL on a load edge (reload) or on a shift edge that is not the last one.
- SH_FULL to SH_EMPTY on the 32nd shift edge after a load.

The capture latch has two states, CAP_IDLE and CAP_HIT:
- CAP_IDLE to CAP_HIT when armed with the selected status low.
- CAP_HIT to CAP_IDLE when disarmed with the selected status high.

Top module: `result_serializer`

## Requirements
- R1: After reset the serial line and both host status lines are 0, and the latch is in CAP_IDLE.
- R2: A rising edge on `ctl_load_i` captures {`bus_hi_i`,`bus_lo_i`} as a 32-bit word W, with `bus_lo_i` in bits 15..0 and `bus_hi_i` in bits 31..16. After the load the serial line shows W[0].
- R3: After a load, the k-th rising edge on `ctl_shift_i` makes the serial line show W[k] for k = 1..31. The order is `bus_lo_i` bit 0 up to bit 15, then `bus_hi_i` bit 0 up to bit 15.
- R4: On the 32nd shift edge and on any later shift edge the serial line shows 0, until the next load edge.
- R5: Only edges act. Holding `ctl_load_i` high does not reload, even if the buses change. A shift edge while a level is held still advances the register by one bit.
- R6: While `ser_en_i` is 0 the serial line is 0, and shift edges still advance the register.
- R7: With `ctl_arm_i` high and the selected status input low, the latch enters CAP_HIT.
- R8: The latch leaves CAP_HIT only when `ctl_arm_i` is low and the selected status input is high. With arm low and status low it holds its state. With arm high and status high it also holds its state.
- R9: `stat_sel_i` = n selects `stat_n_i[n]`. A low on an input that is not selected never sets the latch.
- R10: With `route_sel_i` = 0 the latch output drives `host_stat0_o`, and with `route_sel_i` = 1 it drives `host_stat1_o`. The line that is not chosen is 0.
- R11: A low pulse on the selected status input that lasts one clock period, while armed, is captured and held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_load_i | input | 1 | Control bit; its rising edge snapshots both buses |
| ctl_shift_i | input | 1 | Control bit; its rising edge advances the serialiser |
| ctl_arm_i | input | 1 | Control bit that arms (high) or clears (low) capture |
| bus_hi_i | input | BUS_W | Result bus placed in the upper half of the word |
| bus_lo_i | input | BUS_W | Result bus placed in the lower half, shifted out first |
| stat_n_i | input | N_STAT | Active-low status inputs |
| stat_sel_i | input | SEL_W | Index of the status input watched by the latch |
| ser_en_i | input | 1 | Enables the serial line toward the host |
| route_sel_i | input | 1 | Chooses which host status line carries the latch |
| host_ser_o | output | 1 | Serial result bit toward the host |
| host_stat0_o | output | 1 | Host status line 0 |
| host_stat1_o | output | 1 | Host status line 1 |

## Verification
The case that is hardest to reach from the ports is a single-clock low glitch on the selected status input. It has to pass through the synchroniser and still set the latch. The bench drives the input low at one falling edge and high again at the next, so exactly one rising edge samples the low, and then it checks that the chosen host line stays high. The bench also walks every bit of several computed words to cover the exact end of the shift sequence, including the edges after the 32nd shift. For the latch, it sweeps all four status selections against both routings.

// File: rtl/result_serializer_pkg.sv
package result_serializer_pkg;
    typedef enum logic {
        SH_EMPTY = 1'b0,
        SH_FULL  = 1'b1
    } sh_state_e;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HIT  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/shift_engine.sv
module shift_engine
    import result_serializer_pkg::*;
#(
    parameter int SR_W = 32,
    localparam int CNT_W = $clog2(SR_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_edge,
    input  logic            shift_edge,
    input  logic [SR_W-1:0] par_in,
    output logic            ser_bit,
    output sh_state_e       state
);
    sh_state_e       state_q, state_d;
    logic [SR_W-1:0] sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic            last_shift;

    assign last_shift = (cnt_q == CNT_W'(SR_W-1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_EMPTY: if (load_edge) state_d = SH_FULL;
            SH_FULL: begin
                if (load_edge)                     state_d = SH_FULL;
                else if (shift_edge && last_shift) state_d = SH_EMPTY;
            end
        endcase
    end

    // state register with its datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_EMPTY;
            sr_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_edge) begin
                sr_q  <= par_in;
                cnt_q <= '0;
            end else if (shift_edge && state_q == SH_FULL) begin
                sr_q  <= {1'b0, sr_q[SR_W-1:1]};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SH_EMPTY: ser_bit = 1'b0;
            SH_FULL:  ser_bit = sr_q[0];
        endcase
        state = state_q;
    end
endmodule

// File: rtl/cap_latch.sv
module cap_latch
    import result_serializer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       stat_n,
    output logic       hit,
    output cap_state_e state
);
    cap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (arm && !stat_n)  state_d = CAP_HIT;
            CAP_HIT:  if (!arm && stat_n)  state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CAP_IDLE: hit = 1'b0;
            CAP_HIT:  hit = 1'b1;
        endcase
        state = state_q;
    end
endmodule

// File: rtl/result_serializer.sv
module result_serializer
    import result_serializer_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int N_STAT = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SR_W = 2 * BUS_W,
    localparam int SEL_W = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_load_i,
    input  logic              ctl_shift_i,
    input  logic              ctl_arm_i,
    input  logic [BUS_W-1:0]  bus_hi_i,
    input  logic [BUS_W-1:0]  bus_lo_i,
    input  logic [N_STAT-1:0] stat_n_i,
    input  logic [SEL_W-1:0]  stat_sel_i,
    input  logic              ser_en_i,
    input  logic              route_sel_i,
    output logic              host_ser_o,
    output logic              host_stat0_o,
    output logic              host_stat1_o
);
    logic [2:0]        ctl_q;
    logic [N_STAT-1:0] stat_q;
    logic              load_prev_q, shift_prev_q;
    logic              load_edge, shift_edge;
    logic              arm_q, sel_q;
    logic              ser_bit, cap_hit;
    sh_state_e         sh_state;
    cap_state_e        cap_state;

    ser_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ctl_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({ctl_load_i, ctl_shift_i, ctl_arm_i}),
        .q   (ctl_q)
    );

    ser_sync #(.W(N_STAT), .STAGES(SYNC_STAGES), .RST_VAL({N_STAT{1'b1}})) u_stat_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (stat_n_i),
        .q   (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_prev_q  <= 1'b0;
            shift_prev_q <= 1'b0;
        end else begin
            load_prev_q  <= ctl_q[2];
            shift_prev_q <= ctl_q[1];
        end
    end

    assign load_edge  = ctl_q[2] & ~load_prev_q;
    assign shift_edge = ctl_q[1] & ~shift_prev_q;
    assign arm_q      = ctl_q[0];
    assign sel_q      = stat_q[stat_sel_i];

    shift_engine #(.SR_W(SR_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_edge  (load_edge),
        .shift_edge (shift_edge),
        .par_in     ({bus_hi_i, bus_lo_i}),
        .ser_bit    (ser_bit),
        .state      (sh_state)
    );

    cap_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_q),
        .stat_n (sel_q),
        .hit    (cap_hit),
        .state  (cap_state)
    );

    assign host_ser_o   = ser_en_i & ser_bit;
    assign host_stat0_o = cap_hit & ~route_sel_i;
    assign host_stat1_o = cap_hit &  route_sel_i;
endmodule

// File: rtl/serializer_checker.sv
module serializer_checker
    import result_serializer_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       load_edge,
    input logic       arm_q,
    input logic       sel_q,
    input logic       ser_bit,
    input sh_state_e  sh_state,
    input cap_state_e cap_state,
    input logic       ser_en_i,
    input logic       route_sel_i,
    input logic       host_ser_o,
    input logic       host_stat0_o,
    input logic       host_stat1_o
);
    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> sh_state == SH_FULL); // R2
    AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sh_state == SH_EMPTY |-> !ser_bit); // R4
    AST_SER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |-> !host_ser_o); // R6
    AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !sel_q) |=> cap_state == CAP_HIT); // R7
    AST_CAP_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_IDLE && !(arm_q && !sel_q)) |=> cap_state == CAP_IDLE); // R9
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_HIT && !(!arm_q && sel_q)) |=> cap_state == CAP_HIT); // R8
    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_stat0_o && host_stat1_o)); // R10
    AST_ROUTE_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel_i |-> !host_stat0_o); // R10
endmodule

bind result_serializer serializer_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_edge    (load_edge),
    .arm_q        (arm_q),
    .sel_q        (sel_q),
    .ser_bit      (ser_bit),
    .sh_state     (sh_state),
    .cap_state    (cap_state),
    .ser_en_i     (ser_en_i),
    .route_sel_i  (route_sel_i),
    .host_ser_o   (host_ser_o),
    .host_stat0_o (host_stat0_o),
    .host_stat1_o (host_stat1_o)
);

// File: tb/test_result_serializer.sv
`timescale 1ns/1ps
module test_result_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_load_i = 1'b0, ctl_shift_i = 1'b0, ctl_arm_i = 1'b0;
    logic [15:0] bus_hi_i = '0, bus_lo_i = '0;
    logic [3:0]  stat_n_i = 4'hF;
    logic [1:0]  stat_sel_i = '0;
    logic        ser_en_i = 1'b1, route_sel_i = 1'b0;
    logic        host_ser_o, host_stat0_o, host_stat1_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    result_serializer i_result_serializer (
        .clk (clk), .rst_n (rst_n),
        .ctl_load_i (ctl_load_i), .ctl_shift_i (ctl_shift_i), .ctl_arm_i (ctl_arm_i),
        .bus_hi_i (bus_hi_i), .bus_lo_i (bus_lo_i),
        .stat_n_i (stat_n_i), .stat_sel_i (stat_sel_i),
        .ser_en_i (ser_en_i), .route_sel_i (route_sel_i),
        .host_ser_o (host_ser_o), .host_stat0_o (host_stat0_o), .host_stat1_o (host_stat1_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_load();
        ctl_load_i = 1'b1; settle();
        ctl_load_i = 1'b0; settle();
    endtask

    task automatic pulse_shift();
        ctl_shift_i = 1'b1; settle();
        ctl_shift_i = 1'b0; settle();
    endtask

    task automatic load_word(input logic [31:0] w);
        bus_hi_i = w[31:16];
        bus_lo_i = w[15:0];
        pulse_load();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ser", {31'b0, host_ser_o}, 32'd0);
        check("R1 stat0", {31'b0, host_stat0_o}, 32'd0);
        check("R1 stat1", {31'b0, host_stat1_o}, 32'd0);
        rst_n = 1'b1;
        settle();
        check("R1 after release", {29'b0, host_ser_o, host_stat0_o, host_stat1_o}, 32'd0);
        pulse_shift();
        check("R4 shift while empty", {31'b0, host_ser_o}, 32'd0);

        // R2, R3, R4: walk several computed words bit by bit
        for (int p = 0; p < 5; p++) begin
            w = (p == 0) ? 32'hFFFF_FFFF : (32'h9E37_79B9 * (p + 1)) ^ (32'h1 << (p * 7));
            load_word(w);
            check("R2 first bit", {31'b0, host_ser_o}, {31'b0, w[0]});
            for (int k = 1; k < 32; k++) begin
                pulse_shift();
                check("R3 bit order", {31'b0, host_ser_o}, {31'b0, w[k]});
            end
            for (int x = 0; x < 3; x++) begin
                pulse_shift();
                check("R4 drained", {31'b0, host_ser_o}, 32'd0);
            end
        end

        // R5: level on load does not reload; shift still works under held load
        w = 32'h0000_0005;
        bus_hi_i = w[31:16]; bus_lo_i = w[15:0];
        ctl_load_i = 1'b1; settle();
        check("R5 loaded", {31'b0, host_ser_o}, 32'd1);
        bus_hi_i = 16'hFFFF; bus_lo_i = 16'hFFFA;
        settle();
        check("R5 no reload on level", {31'b0, host_ser_o}, 32'd1);
        pulse_shift();
        check("R5 shift under held load", {31'b0, host_ser_o}, 32'd0);
        pulse_shift();
        check("R5 second shift", {31'b0, host_ser_o}, 32'd1);
        ctl_load_i = 1'b0; settle();

        // R6: gating leaves the register advancing
        load_word(32'h0000_0016);
        ser_en_i = 1'b0;
        settle();
        check("R6 gated", {31'b0, host_ser_o}, 32'd0);
        pulse_shift();
        check("R6 gated after shift", {31'b0, host_ser_o}, 32'd0);
        pulse_shift();
        ser_en_i = 1'b1;
        settle();
        check("R6 advanced while gated", {31'b0, host_ser_o}, 32'd1);
        pulse_shift();
        check("R6 next bit", {31'b0, host_ser_o}, 32'd0);

        // R7..R10: sweep select and route
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 2; r++) begin
                stat_sel_i = s[1:0];
                route_sel_i = r[0];
                ctl_arm_i = 1'b0; stat_n_i = 4'hF; settle();
                check("R8 cleared", {30'b0, host_stat1_o, host_stat0_o}, 32'd0);
                ctl_arm_i = 1'b1;
                stat_n_i = ~(4'hF & ~(4'b1 << s));
                settle();
                check("R9 other inputs ignored", {30'b0, host_stat1_o, host_stat0_o}, 32'd0);
                stat_n_i = ~(4'b1 << s);
                settle();
                check("R7 R10 set and routed", {30'b0, host_stat1_o, host_stat0_o}, (r == 0) ? 32'd1 : 32'd2);
                stat_n_i = 4'hF; settle();
                check("R8 hold armed", {30'b0, host_stat1_o, host_stat0_o}, (r == 0) ? 32'd1 : 32'd2);
                ctl_arm_i = 1'b0; stat_n_i = ~(4'b1 << s); settle();
                check("R8 hold low status", {30'b0, host_stat1_o, host_stat0_o}, (r == 0) ? 32'd1 : 32'd2);
                stat_n_i = 4'hF; settle();
                check("R8 clear", {30'b0, host_stat1_o, host_stat0_o}, 32'd0);
            end
        end

        // R11: one-clock glitch on the selected input
        stat_sel_i = 2'd2; route_sel_i = 1'b1; ctl_arm_i = 1'b1; settle();
        check("R11 idle before glitch", {30'b0, host_stat1_o, host_stat0_o}, 32'd0);
        stat_n_i = 4'b1011;
        @(negedge clk);
        stat_n_i = 4'hF;
        settle();
        check("R11 glitch captured", {30'b0, host_stat1_o, host_stat0_o}, 32'd2);
        settle();
        check("R11 glitch held", {30'b0, host_stat1_o, host_stat0_o}, 32'd2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule